// File: doc/BRIEF.md
# Hashed Offset Table Engine

This block keeps the dictionary state that a hash-based decompressor needs in order to stay in step with the compressor that produced its input. Every time the literal path sees three consecutive output bytes, it presents them together with the current output write position. The block hashes the three bytes into a 12-bit row number. It then records the write position in an offset table and the first two of the three bytes in a side table, both at that row.

When the parser meets a copy item, it presents the row number carried by that item. One clock later the block returns the stored position and the two stored leading bytes. The two leading bytes let the literal path join the start of the copied string onto the literals that came before it, without touching the output memory. A lookup that targets the row written in the cycle just before it is served by a comparator from the write staging register, so it never sees stale memory contents.

Row 1264 of both tables comes out of reset already holding a default entry. That entry is position zero with leading bytes "1" and "2", and it stays in place until a literal overwrites it. Cycles marked as control bytes or idle leave both tables untouched.

Top module: `offset_dict_engine`

## Requirements
- R1: `hash_idx` equals bits [15:4] of the product 40543 × K, where K = (seq_b0 << 8) XOR (seq_b1 << 4) XOR seq_b2 and seq_b0 is the earliest byte; it follows the byte inputs combinationally.
- R2: With `op_mode` = 2'b01 (literal), the row `hash_idx` of the offset table takes `wr_pos`, and the same row of the side table takes {seq_b0, seq_b1}. A later lookup of that row returns `wr_pos` unchanged on `look_pos` (memory number in bits [15:11], address in bits [10:0]), seq_b0 on `look_b0` and seq_b1 on `look_b1`.
- R3: After reset, a lookup of row 1264 returns position 0 with `look_b0` = 8'h31 and `look_b1` = 8'h32, until a literal writes row 1264; after that, it returns the written values.
- R4: With `op_mode` = 2'b10 (copy lookup) in a cycle, `look_vld` is high in the next cycle with the data of row `copy_idx`. After any other mode, and out of reset, `look_vld` is low.
- R5: `look_pos`, `look_b0` and `look_b1` keep their values through cycles that follow a mode other than copy lookup.
- R6: `op_mode` = 2'b11 (control byte) and 2'b00 (idle) write neither table, whatever the byte and position inputs carry.
- R7: A lookup issued in the cycle right after a literal, with `copy_idx` equal to that literal's row, returns the literal's position and bytes.
- R8: When one row is written more than once, a lookup returns the most recent write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 2 | 00 idle, 01 literal update, 10 copy lookup, 11 control byte |
| seq_b0 | input | 8 | Earliest of the three literal bytes |
| seq_b1 | input | 8 | Middle literal byte |
| seq_b2 | input | 8 | Latest literal byte |
| wr_pos | input | 16 | Output write position: memory number [15:11], address [10:0] |
| copy_idx | input | 12 | Row number carried by a copy item |
| hash_idx | output | 12 | Row number hashed from the three literal bytes |
| look_vld | output | 1 | Lookup result valid |
| look_pos | output | 16 | Stored position of the looked-up row |
| look_b0 | output | 8 | First stored leading byte |
| look_b1 | output | 8 | Second stored leading byte |

## Verification
The hash is exercised with all-zero bytes, all-ones bytes and two dozen spread byte triples; each is compared against an arithmetic model, which separates errors in shift amounts, in byte order and in which product bits are taken. Lookups are issued some time after their writes, so they read memory, and also right after their writes, so they read the staging register; the two cases tell a fault in the table apart from a fault in the forwarding comparator. Rewrites of one row, control and idle cycles that carry live-looking bytes, and reads of the default row before and after it is overwritten separate ordering, write-gating and preload faults.

// File: rtl/offset_dict_pkg.sv
package offset_dict_pkg;

    // Operation presented on op_mode each cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LIT  = 2'b01,
        OP_COPY = 2'b10,
        OP_CTRL = 2'b11
    } odt_op_e;

endpackage

// File: rtl/odt_hash.sv
module odt_hash #(
    parameter int BYTE_W     = 8,
    parameter int IDX_W      = 12,
    parameter int HASH_MUL   = 40543,
    parameter int MUL_W      = 16,
    parameter int HASH_SHIFT = 4
) (
    input  logic [BYTE_W-1:0] b0,
    input  logic [BYTE_W-1:0] b1,
    input  logic [BYTE_W-1:0] b2,
    output logic [IDX_W-1:0]  idx
);
    localparam int KEY_W  = 2 * BYTE_W;
    localparam int PROD_W = KEY_W + MUL_W;
    localparam int MID_SH = BYTE_W / 2;

    logic [KEY_W-1:0]  key_c;
    logic [PROD_W-1:0] prod_c;

    always_comb begin
        key_c  = (KEY_W'(b0) << BYTE_W) ^ (KEY_W'(b1) << MID_SH) ^ KEY_W'(b2);
        prod_c = PROD_W'(key_c) * PROD_W'(HASH_MUL);
        idx    = prod_c[HASH_SHIFT +: IDX_W];
    end

endmodule

// File: rtl/odt_bank.sv
module odt_bank #(
    parameter int             W        = 16,
    parameter int             IDX_W    = 12,
    parameter int             DFLT_ROW = 1264,
    parameter logic [W-1:0]   DFLT_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    localparam int               DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] DROW  = IDX_W'(DFLT_ROW);

    logic [W-1:0] mem_q [DEPTH];
    logic         pristine_d, pristine_q;

    // Row storage carries no reset; the preload row is covered by pristine_q
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        pristine_d = pristine_q && !(we && (waddr == DROW));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pristine_q <= 1'b1;
        end else begin
            pristine_q <= pristine_d;
        end
    end

    assign rdata = (pristine_q && (raddr == DROW)) ? DFLT_VAL : mem_q[raddr];

    // R3: the preload stays in force until a write actually lands on its row
    a_r3_default_until_written: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pristine_q) |-> $past(we && (waddr == DROW)));

endmodule

// File: rtl/offset_dict_engine.sv
module offset_dict_engine
    import offset_dict_pkg::*;
#(
    parameter int                BYTE_W     = 8,
    parameter int                IDX_W      = 12,
    parameter int                BANK_W     = 5,
    parameter int                ADDR_W     = 11,
    parameter int                DFLT_ROW   = 1264,
    parameter int                HASH_MUL   = 40543,
    parameter int                HASH_SHIFT = 4,
    parameter logic [BYTE_W-1:0] DFLT_B0    = 8'h31,
    parameter logic [BYTE_W-1:0] DFLT_B1    = 8'h32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               op_mode,
    input  logic [BYTE_W-1:0]        seq_b0,
    input  logic [BYTE_W-1:0]        seq_b1,
    input  logic [BYTE_W-1:0]        seq_b2,
    input  logic [BANK_W+ADDR_W-1:0] wr_pos,
    input  logic [IDX_W-1:0]         copy_idx,
    output logic [IDX_W-1:0]         hash_idx,
    output logic                     look_vld,
    output logic [BANK_W+ADDR_W-1:0] look_pos,
    output logic [BYTE_W-1:0]        look_b0,
    output logic [BYTE_W-1:0]        look_b1
);
    localparam int POS_W  = BANK_W + ADDR_W;
    localparam int PAIR_W = 2 * BYTE_W;

    typedef struct packed {
        logic              wr_vld;   // staged write commits at next edge
        logic [IDX_W-1:0]  wr_idx;   // row of the most recent literal
        logic [POS_W-1:0]  wr_pos;
        logic [PAIR_W-1:0] wr_pair;
        logic              seen;     // at least one literal since reset
        logic              rd_vld;
        logic [POS_W-1:0]  rd_pos;
        logic [PAIR_W-1:0] rd_pair;
    } eng_state_t;

    eng_state_t        s_d, s_q;
    odt_op_e           op_c;
    logic              fwd_hit_c;
    logic [POS_W-1:0]  pos_rdata;
    logic [PAIR_W-1:0] pair_rdata;

    odt_hash #(
        .BYTE_W     (BYTE_W),
        .IDX_W      (IDX_W),
        .HASH_MUL   (HASH_MUL),
        .MUL_W      (16),
        .HASH_SHIFT (HASH_SHIFT)
    ) u_hash (
        .b0  (seq_b0),
        .b1  (seq_b1),
        .b2  (seq_b2),
        .idx (hash_idx)
    );

    odt_bank #(
        .W        (POS_W),
        .IDX_W    (IDX_W),
        .DFLT_ROW (DFLT_ROW),
        .DFLT_VAL ('0)
    ) u_pos_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (s_q.wr_vld),
        .waddr (s_q.wr_idx),
        .wdata (s_q.wr_pos),
        .raddr (copy_idx),
        .rdata (pos_rdata)
    );

    odt_bank #(
        .W        (PAIR_W),
        .IDX_W    (IDX_W),
        .DFLT_ROW (DFLT_ROW),
        .DFLT_VAL ({DFLT_B0, DFLT_B1})
    ) u_pair_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (s_q.wr_vld),
        .waddr (s_q.wr_idx),
        .wdata (s_q.wr_pair),
        .raddr (copy_idx),
        .rdata (pair_rdata)
    );

    always_comb begin
        s_d        = s_q;
        s_d.wr_vld = 1'b0;
        s_d.rd_vld = 1'b0;
        op_c       = odt_op_e'(op_mode);
        // The staging register always holds the latest write to its row
        fwd_hit_c  = s_q.seen && (copy_idx == s_q.wr_idx);

        case (op_c)
            OP_LIT: begin
                s_d.wr_vld  = 1'b1;
                s_d.wr_idx  = hash_idx;
                s_d.wr_pos  = wr_pos;
                s_d.wr_pair = {seq_b0, seq_b1};
                s_d.seen    = 1'b1;
            end
            OP_COPY: begin
                s_d.rd_vld  = 1'b1;
                s_d.rd_pos  = fwd_hit_c ? s_q.wr_pos  : pos_rdata;
                s_d.rd_pair = fwd_hit_c ? s_q.wr_pair : pair_rdata;
            end
            default: begin
                // idle and control bytes: tables and results untouched
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign look_vld = s_q.rd_vld;
    assign look_pos = s_q.rd_pos;
    assign look_b0  = s_q.rd_pair[PAIR_W-1 -: BYTE_W];
    assign look_b1  = s_q.rd_pair[BYTE_W-1:0];

    // R4: a lookup answers exactly one cycle later
    a_r4_vld_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == OP_COPY) |=> look_vld);

    a_r4_no_vld_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode != OP_COPY) |=> !look_vld);

    // R5: results hold when no lookup was issued
    a_r5_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode != OP_COPY) |=> ($stable(look_pos) && $stable(look_b0) && $stable(look_b1)));

    // R6: idle and control cycles never stage a table write
    a_r6_no_write_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_mode == OP_CTRL) || (op_mode == OP_IDLE)) |=> !s_q.wr_vld);

    // R7: a lookup right behind a literal of the same row sees that literal
    a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(op_mode) == OP_LIT) && (op_mode == OP_COPY) && (copy_idx == $past(hash_idx)))
        |=> ((look_pos == $past(wr_pos, 2)) && (look_b0 == $past(seq_b0, 2))
             && (look_b1 == $past(seq_b1, 2))));

endmodule

// File: tb/offset_dict_engine_tb.sv
module offset_dict_engine_tb;

    localparam logic [1:0] M_IDLE = 2'b00;
    localparam logic [1:0] M_LIT  = 2'b01;
    localparam logic [1:0] M_COPY = 2'b10;
    localparam logic [1:0] M_CTRL = 2'b11;
    localparam int         DROW   = 1264;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_mode = M_IDLE;
    logic [7:0]  seq_b0 = '0, seq_b1 = '0, seq_b2 = '0;
    logic [15:0] wr_pos = '0;
    logic [11:0] copy_idx = '0;
    logic [11:0] hash_idx;
    logic        look_vld;
    logic [15:0] look_pos;
    logic [7:0]  look_b0, look_b1;

    int vectors = 0;
    int miscompares = 0;

    typedef struct {
        logic [15:0] pos;
        logic [7:0]  b0;
        logic [7:0]  b1;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;
    int   m_pos[int];
    int   m_pair[int];
    bit   prev_copy = 1'b0;

    always #2.5 clk = ~clk;

    offset_dict_engine u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_mode  (op_mode),
        .seq_b0   (seq_b0),
        .seq_b1   (seq_b1),
        .seq_b2   (seq_b2),
        .wr_pos   (wr_pos),
        .copy_idx (copy_idx),
        .hash_idx (hash_idx),
        .look_vld (look_vld),
        .look_pos (look_pos),
        .look_b0  (look_b0),
        .look_b1  (look_b1)
    );

    function automatic int ref_hash(input int a, input int b, input int c);
        longint key;
        longint prod;
        key  = longint'((a << 8) ^ (b << 4) ^ c);
        prod = 64'd40543 * key;
        return int'((prod >> 4) & 64'hFFF);
    endfunction

    function automatic void pattern(input int i, output logic [7:0] a,
                                    output logic [7:0] b, output logic [7:0] c);
        if (i == 0) begin
            a = 8'h00; b = 8'h00; c = 8'h00;
        end else if (i == 1) begin
            a = 8'hFF; b = 8'hFF; c = 8'hFF;
        end else begin
            a = 8'((i * 53 + 7) & 255);
            b = 8'((i * 29 + 100) & 255);
            c = 8'((i * 71 + 3) & 255);
        end
    endfunction

    task automatic report(input string tag, input string what,
                          input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and updates the scoreboard model
    task automatic step(input logic [1:0] m, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [15:0] p, input int ridx,
                        input string tag);
        exp_t e;
        int   h;
        @(negedge clk);
        report("R4", "look_vld timing", longint'(look_vld), longint'(prev_copy));
        op_mode  = m;
        seq_b0   = a;
        seq_b1   = b;
        seq_b2   = c;
        wr_pos   = p;
        copy_idx = 12'(ridx);
        if (m == M_COPY) begin
            e.tag = tag;
            if (m_pos.exists(ridx)) begin
                e.pos = 16'(m_pos[ridx]);
                e.b0  = 8'(m_pair[ridx] >> 8);
                e.b1  = 8'(m_pair[ridx]);
            end else begin
                e.pos = 16'h0000;
                e.b0  = 8'h31;
                e.b1  = 8'h32;
            end
            exp_q.push_back(e);
            last_exp = e;
        end
        if (m == M_LIT) begin
            h = ref_hash(a, b, c);
            #1;
            report("R1", "hash_idx", longint'(hash_idx), longint'(h));
            m_pos[h]  = int'(p);
            m_pair[h] = (int'(a) << 8) | int'(b);
        end
        prev_copy = (m == M_COPY);
    endtask

    // Monitor: pops expected lookup results as the design produces them
    always @(negedge clk) begin
        if (rst_n && look_vld) begin
            if (exp_q.size() == 0) begin
                report("R4", "unexpected look_vld", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                report(e.tag, "look_pos", longint'(look_pos), longint'(e.pos));
                report(e.tag, "look_b0", longint'(look_b0), longint'(e.b0));
                report(e.tag, "look_b1", longint'(look_b1), longint'(e.b1));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] a, b, c;
        int         h;
        bit         found;
        logic [7:0] fa, fb, fc;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        report("R4", "look_vld after reset", longint'(look_vld), 0);

        // R3: preload of the default row
        step(M_COPY, 0, 0, 0, 0, DROW, "R3");

        // R1/R2: a spread of literal triples, then lookups well after writing
        for (int i = 0; i < 24; i++) begin
            pattern(i, a, b, c);
            step(M_LIT, a, b, c, 16'(((i & 31) << 11) | ((i * 71) & 2047)), 0, "R2");
        end
        step(M_IDLE, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 24; i++) begin
            pattern(i, a, b, c);
            step(M_COPY, 0, 0, 0, 0, ref_hash(a, b, c), "R2");
        end

        // R7: lookup issued in the cycle right after its literal
        for (int i = 30; i < 33; i++) begin
            pattern(i, a, b, c);
            step(M_LIT, a, b, c, 16'(16'hA000 + i), 0, "R7");
            step(M_COPY, 0, 0, 0, 0, ref_hash(a, b, c), "R7");
        end

        // R8: the latest of several writes to one row wins
        pattern(4, a, b, c);
        step(M_LIT, a, b, c, 16'h1111, 0, "R8");
        pattern(9, a, b, c);
        step(M_LIT, a, b, c, 16'h2222, 0, "R8");
        pattern(4, a, b, c);
        step(M_LIT, a, b, c, 16'h7FFE, 0, "R8");
        step(M_IDLE, 0, 0, 0, 0, 0, "R8");
        step(M_IDLE, 0, 0, 0, 0, 0, "R8");
        step(M_COPY, 0, 0, 0, 0, ref_hash(a, b, c), "R8");

        // R6: control and idle cycles carrying live-looking inputs write nothing
        pattern(5, a, b, c);
        step(M_CTRL, a, b, c, 16'hDEAD, 0, "R6");
        step(M_IDLE, a, b, c, 16'hBEEF, 0, "R6");
        step(M_CTRL, 8'h9C, 8'h9C, 8'h9C, 16'hCAFE, 0, "R6");
        step(M_IDLE, 0, 0, 0, 0, 0, "R6");
        step(M_COPY, 0, 0, 0, 0, ref_hash(a, b, c), "R6");

        // R5: results hold through non-lookup cycles
        step(M_IDLE, 8'h55, 8'hAA, 8'h0F, 16'h4321, 12'hABC, "R5");
        #1;
        report("R5", "look_pos hold", longint'(look_pos), longint'(last_exp.pos));
        step(M_CTRL, 8'h12, 8'h34, 8'h56, 16'h0F0F, 12'h123, "R5");
        #1;
        report("R5", "look_pos hold", longint'(look_pos), longint'(last_exp.pos));
        report("R5", "look_b0 hold", longint'(look_b0), longint'(last_exp.b0));
        report("R5", "look_b1 hold", longint'(look_b1), longint'(last_exp.b1));

        // R3: default row before and after being overwritten
        step(M_COPY, 0, 0, 0, 0, DROW, "R3");
        found = 1'b0;
        fa = '0; fb = '0; fc = '0;
        for (int x = 0; x < 256 && !found; x++) begin
            for (int y = 0; y < 256 && !found; y++) begin
                h = ref_hash(x, y, 8'h41);
                if (h == DROW) begin
                    found = 1'b1;
                    fa = 8'(x); fb = 8'(y); fc = 8'h41;
                end
            end
        end
        if (found) begin
            step(M_LIT, fa, fb, fc, 16'h1234, 0, "R3");
            step(M_IDLE, 0, 0, 0, 0, 0, "R3");
            step(M_COPY, 0, 0, 0, 0, DROW, "R3");
        end

        step(M_IDLE, 0, 0, 0, 0, 0, "R4");
        step(M_IDLE, 0, 0, 0, 0, 0, "R4");
        report("R4", "pending lookups", longint'(exp_q.size()), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule